// File: doc/BRIEF.md
# Prioritized Interrupt Controller with DMA Routing

This block collects interrupt requests from 36 peripheral channels. Each channel has a sticky request flag, and each maskable channel has a 3-bit priority level that software can program. On every clock, one arbiter picks the strongest pending request that is allowed through. That request, its level and its vector (the channel index) are presented to the CPU on registered outputs. When the CPU acknowledges the request, the block raises its own copy of the CPU mask level and saves the previous mask on a seven-entry stack. A return-from-interrupt pulse pops that stack.

Channel 0 is the non-maskable watchdog source. Its level is fixed at 7 and it reaches the CPU whatever the mask holds. Software can route up to four channels to a micro-DMA engine by writing their vectors into steering registers. A routed channel raises a DMA request pulse instead of interrupting the CPU.

Register map (8-bit data):
- Addresses 0 to 17 are priority registers. Address a holds channel 2a in bits 2:0, with that channel's live flag in bit 3. It holds channel 2a+1 in bits 6:4, with that channel's live flag in bit 7.
- Address 18 is a write-only clear port.
- Addresses 19 to 22 are the four DMA steering registers.

Top module: `irq_arbiter`

## Requirements
- R1: A one-cycle pulse on `req_in[i]` sets flag i, and the flag holds until one of the clear events listed here. Reset clears all flags, sets the mask to 0 and drives `cpu_irq` and `dma_req` low. Flag i reads back in bit 3 (even i) or bit 7 (odd i) of priority register i/2.
- R2: A written priority field reads back unchanged. Levels 1 to 6 let a pending channel compete. Levels 0 and 7 keep it from ever reaching `cpu_irq` or `dma_req`.
- R3: Channel 0 always reads back level 7 and ignores writes to its field. When its flag is set, it is forwarded at level 7 regardless of the mask.
- R4: Among the eligible CPU requests, the highest level wins. On a tie in level, the lowest vector wins.
- R5: A maskable channel is forwarded only when its level is strictly greater than `mask_lvl`. The outputs `cpu_irq`, `cpu_level` and `cpu_vec` are registered and reflect flag, priority and mask state one clock after that state changes.
- R6: A `cpu_ack` pulse does three things. It clears the flag of `ack_vec`. It sets `mask_lvl` to the acknowledged channel's level plus 1, or to 7 for level 7. It pushes the previous mask onto the stack.
- R7: A `cpu_reti` pulse restores the most recently pushed mask. With an empty stack it leaves `mask_lvl` unchanged.
- R8: Writing a vector value to address 18 clears that channel's flag.
- R9: Addresses 19 to 22 hold steering vectors, and they read back as written. Consider a pending channel with an active level whose vector equals a nonzero steering vector. It never reaches `cpu_irq`. Instead it produces a one-cycle `dma_req` with `dma_vec`, chosen by highest level and then lowest vector. Its flag clears on that same edge.
- R10: A `dma_done` pulse clears the flag named by `done_vec`.
- R11: A request pulse that arrives in the same cycle as any clear of the same channel leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_in | input | 36 | Peripheral request pulses, one per channel |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address for write and readback |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Combinational readback of `reg_addr` |
| cpu_irq | output | 1 | Request presented to the CPU |
| cpu_level | output | 3 | Level of the presented request |
| cpu_vec | output | 6 | Vector of the presented request |
| cpu_ack | input | 1 | CPU acceptance pulse |
| ack_vec | input | 6 | Vector being accepted |
| cpu_reti | input | 1 | Return-from-interrupt pulse |
| mask_lvl | output | 3 | Current CPU mask level |
| dma_req | output | 1 | Micro-DMA start pulse |
| dma_vec | output | 6 | Vector of the DMA request |
| dma_done | input | 1 | DMA burst end pulse |
| done_vec | input | 6 | Vector whose burst ended |

## Verification
A channel's flag can be cleared and set in the same cycle. The clear can come from a CPU acknowledge of that vector or from a write of the vector to the clear port, while a fresh request pulse arrives on the same channel. The bench drives both pairs on the same clock edge and then reads the flag back through the priority register. A flag that reads 0 means a request was lost. The bench also checks that the acknowledge still moved the mask as it would without the collision.

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int NCH  = 36,
  parameter int NDMA = 4,
  parameter int STK  = 7,
  localparam int VW  = $clog2(NCH),
  localparam int NPR = (NCH + 1) / 2,
  localparam int AW  = $clog2(NPR + 1 + NDMA)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] req_in,
  input  logic           reg_we,
  input  logic [AW-1:0]  reg_addr,
  input  logic [7:0]     reg_wdata,
  output logic [7:0]     reg_rdata,
  output logic           cpu_irq,
  output logic [2:0]     cpu_level,
  output logic [VW-1:0]  cpu_vec,
  input  logic           cpu_ack,
  input  logic [VW-1:0]  ack_vec,
  input  logic           cpu_reti,
  output logic [2:0]     mask_lvl,
  output logic           dma_req,
  output logic [VW-1:0]  dma_vec,
  input  logic           dma_done,
  input  logic [VW-1:0]  done_vec
);
  localparam int CLR_A = NPR;
  localparam int DMA_A = NPR + 1;
  localparam int SPW   = $clog2(STK + 1);

  logic [NCH-1:0] flag, on, routed, clr;
  logic [2:0]     prio [NCH];
  logic [2:0]     lvl  [NCH];
  logic [VW-1:0]  dvec [NDMA];
  logic [2:0]     stk  [STK];
  logic [SPW-1:0] sp;
  logic [2:0]     mask;

  logic           c_any, d_any;
  logic [2:0]     c_lvl, d_lvl, a_lvl, a_mask;
  logic [VW-1:0]  c_vec, d_vec;

  assign mask_lvl = mask;

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      lvl[i]    = (i == 0) ? 3'd7 : prio[i];
      on[i]     = (i == 0) || (prio[i] != 3'd0 && prio[i] != 3'd7);
      routed[i] = 1'b0;
      for (int k = 0; k < NDMA; k++)
        if (i != 0 && dvec[k] == VW'(i)) routed[i] = 1'b1;
    end
  end

  always_comb begin
    c_any = 1'b0; c_lvl = '0; c_vec = '0;
    d_any = 1'b0; d_lvl = '0; d_vec = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (flag[i] && on[i] && !routed[i] && (i == 0 || lvl[i] > mask) &&
          (!c_any || lvl[i] >= c_lvl)) begin
        c_any = 1'b1; c_lvl = lvl[i]; c_vec = VW'(i);
      end
      if (flag[i] && on[i] && routed[i] && (!d_any || lvl[i] >= d_lvl)) begin
        d_any = 1'b1; d_lvl = lvl[i]; d_vec = VW'(i);
      end
    end
  end

  assign a_lvl  = (int'(ack_vec) < NCH) ? lvl[ack_vec] : 3'd0;
  assign a_mask = (a_lvl == 3'd7) ? 3'd7 : a_lvl + 3'd1;

  always_comb begin
    clr = '0;
    if (cpu_ack && int'(ack_vec) < NCH) clr[ack_vec] = 1'b1;
    if (reg_we && int'(reg_addr) == CLR_A && int'(reg_wdata[VW-1:0]) < NCH)
      clr[reg_wdata[VW-1:0]] = 1'b1;
    if (d_any) clr[d_vec] = 1'b1;
    if (dma_done && int'(done_vec) < NCH) clr[done_vec] = 1'b1;
  end

  always_comb begin
    reg_rdata = '0;
    for (int p = 0; p < NPR; p++)
      if (int'(reg_addr) == p) begin
        reg_rdata[2:0] = lvl[2*p];
        reg_rdata[3]   = flag[2*p];
        if (2*p + 1 < NCH) begin
          reg_rdata[6:4] = lvl[2*p+1];
          reg_rdata[7]   = flag[2*p+1];
        end
      end
    for (int k = 0; k < NDMA; k++)
      if (int'(reg_addr) == DMA_A + k) reg_rdata = 8'(dvec[k]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag      <= '0;
      cpu_irq   <= 1'b0;
      cpu_level <= '0;
      cpu_vec   <= '0;
      dma_req   <= 1'b0;
      dma_vec   <= '0;
      mask      <= '0;
      sp        <= '0;
      for (int i = 0; i < NCH; i++) prio[i] <= '0;
      for (int k = 0; k < NDMA; k++) dvec[k] <= '0;
      for (int s = 0; s < STK; s++) stk[s] <= '0;
    end else begin
      flag      <= (flag & ~clr) | req_in;
      cpu_irq   <= c_any;
      cpu_level <= c_lvl;
      cpu_vec   <= c_vec;
      dma_req   <= d_any;
      dma_vec   <= d_vec;
      for (int p = 0; p < NPR; p++)
        if (reg_we && int'(reg_addr) == p) begin
          if (p != 0) prio[2*p] <= reg_wdata[2:0];
          if (2*p + 1 < NCH) prio[2*p+1] <= reg_wdata[6:4];
        end
      for (int k = 0; k < NDMA; k++)
        if (reg_we && int'(reg_addr) == DMA_A + k) dvec[k] <= reg_wdata[VW-1:0];
      if (cpu_ack) begin
        mask <= a_mask;
        if (int'(sp) < STK) begin
          stk[sp] <= mask;
          sp      <= sp + SPW'(1);
        end
      end else if (cpu_reti && sp != '0) begin
        mask <= stk[sp - SPW'(1)];
        sp   <= sp - SPW'(1);
      end
    end
  end
endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk #(
  parameter int NCH = 36,
  localparam int VW = $clog2(NCH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_irq,
  input logic [2:0]    cpu_level,
  input logic [VW-1:0] cpu_vec,
  input logic          cpu_ack,
  input logic [VW-1:0] ack_vec,
  input logic [2:0]    mask_lvl,
  input logic          dma_req,
  input logic [VW-1:0] dma_vec
);
  AST_LEVEL_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> (cpu_level != 3'd0 && int'(cpu_vec) < NCH)); // R2
  AST_NMI_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_irq && cpu_vec == '0) |-> cpu_level == 3'd7); // R3
  AST_ABOVE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_irq && cpu_vec != '0) |-> cpu_level > $past(mask_lvl)); // R5
  AST_ACCEPT_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && cpu_irq && ack_vec == cpu_vec) |=>
      mask_lvl == (($past(cpu_level) == 3'd7) ? 3'd7 : $past(cpu_level) + 3'd1)); // R6
  AST_DMA_NOT_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> !(cpu_irq && cpu_vec == dma_vec)); // R9
endmodule

bind irq_arbiter irq_arbiter_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_irq(cpu_irq), .cpu_level(cpu_level),
  .cpu_vec(cpu_vec), .cpu_ack(cpu_ack), .ack_vec(ack_vec),
  .mask_lvl(mask_lvl), .dma_req(dma_req), .dma_vec(dma_vec)
);

// File: tb/sim_irq_arbiter.sv
module sim_irq_arbiter;
  localparam int CLK_P = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [35:0] req_in = '0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0, reg_rdata;
  logic        cpu_irq, cpu_ack = 1'b0, cpu_reti = 1'b0;
  logic [2:0]  cpu_level, mask_lvl;
  logic [5:0]  cpu_vec, ack_vec = '0, dma_vec, done_vec = '0;
  logic        dma_req, dma_done = 1'b0;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  irq_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cpu_irq(cpu_irq), .cpu_level(cpu_level), .cpu_vec(cpu_vec),
    .cpu_ack(cpu_ack), .ack_vec(ack_vec), .cpu_reti(cpu_reti),
    .mask_lvl(mask_lvl), .dma_req(dma_req), .dma_vec(dma_vec),
    .dma_done(dma_done), .done_vec(done_vec)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic tick(); @(negedge clk); endtask

  task automatic chk(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", r, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    reg_we = 1'b1; reg_addr = 5'(a); reg_wdata = 8'(d); tick();
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(string r, int a, int exp);
    reg_addr = 5'(a); #1; chk(r, reg_rdata, exp);
  endtask

  task automatic pulse(int ch);
    req_in[ch] = 1'b1; tick(); req_in = '0;
  endtask

  task automatic ack(int v);
    cpu_ack = 1'b1; ack_vec = 6'(v); tick(); cpu_ack = 1'b0;
  endtask

  task automatic reti();
    cpu_reti = 1'b1; tick(); cpu_reti = 1'b0;
  endtask

  task automatic irq_chk(string r, int v, int l, int vec);
    chk({r, " irq"}, cpu_irq, v);
    if (v != 0) begin
      chk({r, " level"}, cpu_level, l);
      chk({r, " vec"}, cpu_vec, vec);
    end
  endtask

  task automatic t_reset();
    chk("R1 reset irq", cpu_irq, 0);
    chk("R1 reset dma", dma_req, 0);
    chk("R1 reset mask", mask_lvl, 0);
    rd_chk("R1 reset flags", 0, 8'h07);
    rd_chk("R1 reset flags hi", 17, 8'h00);
  endtask

  task automatic t_prio();
    wr(3, 8'h52);
    rd_chk("R2 readback", 3, 8'h52);
    wr(0, 8'h36);
    rd_chk("R3 ch0 fixed", 0, 8'h37);
    wr(0, 8'h00); wr(3, 8'h00);
    rd_chk("R3 ch0 still 7", 0, 8'h07);
  endtask

  task automatic t_disable();
    pulse(9); tick();
    rd_chk("R1 flag latched bit7", 4, 8'h80);
    irq_chk("R2 level0 blocked", 0, 0, 0);
    wr(4, 8'h70); tick();
    irq_chk("R2 level7 blocked", 0, 0, 0);
    wr(4, 8'h40); tick();
    irq_chk("R2 level4 active", 1, 4, 9);
    wr(18, 9);
    rd_chk("R8 clear by vector", 4, 8'h40);
    tick();
    irq_chk("R8 irq drops", 0, 0, 0);
    wr(4, 8'h00);
  endtask

  task automatic t_arb();
    wr(2, 8'h03); wr(5, 8'h05); wr(6, 8'h05);
    pulse(12); pulse(4); pulse(10); tick();
    irq_chk("R4 tie lowest vector", 1, 5, 10);
    wr(18, 10); tick();
    irq_chk("R4 next same level", 1, 5, 12);
    wr(18, 12); tick();
    irq_chk("R4 lower level", 1, 3, 4);
    wr(18, 4); tick();
    irq_chk("R4 none", 0, 0, 0);
  endtask

  task automatic t_mask();
    pulse(4); tick();
    irq_chk("R5 above mask 0", 1, 3, 4);
    ack(4);
    chk("R6 mask level+1", mask_lvl, 4);
    rd_chk("R6 ack clears flag", 2, 8'h03);
    tick();
    irq_chk("R6 irq gone", 0, 0, 0);
    pulse(10); tick();
    irq_chk("R5 5 over 4", 1, 5, 10);
    ack(10);
    chk("R6 mask 6", mask_lvl, 6);
    pulse(4); pulse(12); tick();
    irq_chk("R5 masked", 0, 0, 0);
    rd_chk("R1 flag4 pending", 2, 8'h0B);
    reti(); tick();
    chk("R7 pop to 4", mask_lvl, 4);
    irq_chk("R5 after pop", 1, 5, 12);
    reti();
    chk("R7 pop to 0", mask_lvl, 0);
    wr(18, 12); tick();
    irq_chk("R5 low level open", 1, 3, 4);
    wr(18, 4); tick();
    reti();
    chk("R7 empty stack", mask_lvl, 0);
  endtask

  task automatic t_nmi();
    pulse(10); tick(); ack(10);
    chk("R6 mask 6 pre-nmi", mask_lvl, 6);
    pulse(0); tick();
    irq_chk("R3 nmi over mask", 1, 7, 0);
    ack(0);
    chk("R6 nmi mask 7", mask_lvl, 7);
    tick();
    irq_chk("R3 nmi cleared", 0, 0, 0);
    reti();
    chk("R7 pop 6", mask_lvl, 6);
    reti();
    chk("R7 pop 0", mask_lvl, 0);
  endtask

  task automatic t_same();
    pulse(4); tick();
    cpu_ack = 1'b1; ack_vec = 6'd4; req_in[4] = 1'b1; tick();
    cpu_ack = 1'b0; req_in = '0;
    rd_chk("R11 ack vs new request", 2, 8'h0B);
    chk("R11 mask still moves", mask_lvl, 4);
    reti();
    reg_we = 1'b1; reg_addr = 5'd18; reg_wdata = 8'd4; req_in[4] = 1'b1; tick();
    reg_we = 1'b0; req_in = '0;
    rd_chk("R11 clear vs new request", 2, 8'h0B);
    wr(18, 4);
    rd_chk("R8 final clear", 2, 8'h03);
    tick();
  endtask

  task automatic t_dma();
    wr(19, 5); wr(2, 8'h23);
    rd_chk("R9 steer readback", 19, 5);
    pulse(5); tick();
    chk("R9 dma_req", dma_req, 1);
    chk("R9 dma_vec", dma_vec, 5);
    chk("R9 not to cpu", cpu_irq, 0);
    tick();
    chk("R9 one pulse", dma_req, 0);
    rd_chk("R9 flag cleared on issue", 2, 8'h23);
    wr(19, 0);
    wr(3, 8'h00); pulse(7); tick();
    rd_chk("R10 flag pending", 3, 8'h80);
    chk("R10 no dma", dma_req, 0);
    dma_done = 1'b1; done_vec = 6'd7; tick(); dma_done = 1'b0;
    rd_chk("R10 done clears", 3, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_prio();
    t_disable();
    t_arb();
    t_mask();
    t_nmi();
    t_same();
    t_dma();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule